// File: doc/BRIEF.md
# Two-Bank Fast/Normal Interrupt Controller

This block collects forty level-sensitive interrupt lines and presents them to a processor core on two request outputs: a fast request and a normal request. Sources 0 to 31 sit in the first 32-bit bank. Sources 32 to 39 sit in the low bits of a second bank. Each source has an enable bit and a routing bit, and the routing bit sends it to the fast output or to the normal output. Software sees the raw line levels and two filtered views, which are the enabled normal-routed and the enabled fast-routed sources. It also sees one 7-bit priority word per source, which a separate highest-priority encoder consumes. That encoder's result is fed back in and read through this block.

A wake output tells a halted core that work is waiting. A control bit selects the wake rule. With the bit set, only enabled sources can wake the core. With the bit clear, any active line wakes it.

Software reaches the registers through two paths. The first is a byte-offset register port. The second is a 4-bit coprocessor register number that maps onto the status, enable, routing and highest-priority registers of both banks. Both paths can read in the same cycle. A write arriving on both paths in one cycle is resolved in favour of the offset port.

Top module: `banked_intc`

## Requirements
- R1: Source n with n ≥ 32 appears at bit (n − 32) of every second-bank register. Second-bank enable and routing registers keep only their low 8 bits and read zero above bit 7.
- R2: The raw status (offset 0x10, second bank 0xAC) equals the input levels sampled at the previous clock edge. A bit clears as soon as its line drops, so nothing is latched.
- R3: The normal view (0x00 / 0x9C) reads raw AND enable AND NOT routing. The fast view (0x0C / 0xA8) reads raw AND enable AND routing.
- R4: The enable registers (0x04 / 0xA0) and routing registers (0x08 / 0xA4) read back what was written. A routing bit of 1 selects the fast output.
- R5: `fiq_o` / `irq_o` are registered and show, one clock after any input change or write, whether any enabled source routed fast / normal is active in either bank.
- R6: Control register 0x14 bit 0 reads back as written. `wake_o` is registered and is high only if `halted_i` was high at the edge. When bit 0 is 1 it also needs an enabled active source. When bit 0 is 0 it also needs any active source.
- R7: Priority word n lives at 0x1C + 4n for n < 32 and at 0xB0 + 4(n − 32) otherwise. A write stores only bit 31 and bits 5:0; every other bit reads zero.
- R8: Writes to the status and highest-priority offsets are ignored. Unmapped or non-word-aligned offsets read zero and ignore writes.
- R9: Offset 0x18 and coprocessor number 5 return `hp_code_i`.
- R10: Coprocessor numbers 0–4 select normal view, enable, routing, fast view and raw for bank one. Number 5 selects the highest-priority register. Numbers 6–10 select the same five registers for bank two. Numbers 11–15 read zero and ignore writes.
- R11: When both ports write the same register in one cycle, the offset port's data is stored.
- R12: Reset clears enables, routing, raw status, priorities, control bit 0 and all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 40 | Interrupt line levels |
| halted_i | input | 1 | Core is halted |
| mm_addr_i | input | 8 | Offset port byte address |
| mm_we_i | input | 1 | Offset port write strobe |
| mm_wdata_i | input | 32 | Offset port write data |
| mm_rdata_o | output | 32 | Offset port read data (combinational) |
| cp_reg_i | input | 4 | Coprocessor register number |
| cp_we_i | input | 1 | Coprocessor write strobe |
| cp_wdata_i | input | 32 | Coprocessor write data |
| cp_rdata_o | output | 32 | Coprocessor read data (combinational) |
| hp_code_i | input | 32 | Result from the external priority encoder |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |
| wake_o | output | 1 | Wake request to a halted core |

## Verification
The bench drives a pattern in which enabled, disabled, fast-routed and normal-routed lines are mixed. A design that swapped the routing sense or dropped the enable from a view would then show the wrong bits in the two filtered registers and the wrong request output. Dropping a line afterwards would expose a latched raw status. Writing all ones into a second-bank register would expose storage above bit 7. Writing all ones into a priority word would expose masking that is missing or misplaced. The bench also checks the following cases:
- Wake with the control bit in each state, while a disabled source is active. A design that ignored the control bit would wake, or fail to wake, in the wrong case.
- Misaligned offsets and coprocessor numbers 11 to 15. A design that aliased these would corrupt the enable registers.
- A collision between the two ports. A design that gave the coprocessor path priority would store the wrong word.

// File: rtl/ic_pkg.sv
package ic_pkg;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_IRQP,
        RK_MASK,
        RK_CLASS,
        RK_FIQP,
        RK_RAW,
        RK_CTRL,
        RK_HP,
        RK_PRIO
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic       bank;
        logic [5:0] idx;
    } reg_sel_t;

    // Byte offsets; the coprocessor map and the bench depend on these.
    localparam logic [7:0] OFS_IRQP   = 8'h00;
    localparam logic [7:0] OFS_MASK   = 8'h04;
    localparam logic [7:0] OFS_CLASS  = 8'h08;
    localparam logic [7:0] OFS_FIQP   = 8'h0C;
    localparam logic [7:0] OFS_RAW    = 8'h10;
    localparam logic [7:0] OFS_CTRL   = 8'h14;
    localparam logic [7:0] OFS_HP     = 8'h18;
    localparam logic [7:0] OFS_IRQP2  = 8'h9C;
    localparam logic [7:0] OFS_MASK2  = 8'hA0;
    localparam logic [7:0] OFS_CLASS2 = 8'hA4;
    localparam logic [7:0] OFS_FIQP2  = 8'hA8;
    localparam logic [7:0] OFS_RAW2   = 8'hAC;
    localparam int         PRIO_LO_BASE = 'h1C;
    localparam int         PRIO_HI_BASE = 'hB0;
    localparam logic [7:0] OFS_INVALID  = 8'hFF;  // misaligned: decodes to nothing

endpackage

// File: rtl/ic_cpmap.sv
module ic_cpmap
    import ic_pkg::*;
(
    input  logic [3:0] num_i,
    output logic [7:0] ofs_o
);
    // Numbers 0..4 and 6..10 share the same register order per bank.
    always_comb begin
        unique case (num_i)
            4'd0:    ofs_o = OFS_IRQP;
            4'd1:    ofs_o = OFS_MASK;
            4'd2:    ofs_o = OFS_CLASS;
            4'd3:    ofs_o = OFS_FIQP;
            4'd4:    ofs_o = OFS_RAW;
            4'd5:    ofs_o = OFS_HP;
            4'd6:    ofs_o = OFS_IRQP2;
            4'd7:    ofs_o = OFS_MASK2;
            4'd8:    ofs_o = OFS_CLASS2;
            4'd9:    ofs_o = OFS_FIQP2;
            4'd10:   ofs_o = OFS_RAW2;
            default: ofs_o = OFS_INVALID;
        endcase
    end
endmodule

// File: rtl/ic_decode.sv
module ic_decode
    import ic_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input  logic [7:0] ofs_i,
    output reg_sel_t   sel_o
);
    localparam int HI_CNT = NUM_SRC - 32;
    localparam int LO_END = PRIO_LO_BASE + 4 * 31;
    localparam int HI_END = PRIO_HI_BASE + 4 * (HI_CNT - 1);

    always_comb begin
        sel_o = '{kind: RK_NONE, bank: 1'b0, idx: 6'd0};
        if (ofs_i[1:0] == 2'b00) begin
            case (ofs_i)
                OFS_IRQP:   sel_o.kind = RK_IRQP;
                OFS_MASK:   sel_o.kind = RK_MASK;
                OFS_CLASS:  sel_o.kind = RK_CLASS;
                OFS_FIQP:   sel_o.kind = RK_FIQP;
                OFS_RAW:    sel_o.kind = RK_RAW;
                OFS_CTRL:   sel_o.kind = RK_CTRL;
                OFS_HP:     sel_o.kind = RK_HP;
                OFS_IRQP2:  begin sel_o.kind = RK_IRQP;  sel_o.bank = 1'b1; end
                OFS_MASK2:  begin sel_o.kind = RK_MASK;  sel_o.bank = 1'b1; end
                OFS_CLASS2: begin sel_o.kind = RK_CLASS; sel_o.bank = 1'b1; end
                OFS_FIQP2:  begin sel_o.kind = RK_FIQP;  sel_o.bank = 1'b1; end
                OFS_RAW2:   begin sel_o.kind = RK_RAW;   sel_o.bank = 1'b1; end
                default: begin
                    if (int'(ofs_i) >= PRIO_LO_BASE && int'(ofs_i) <= LO_END) begin
                        sel_o.kind = RK_PRIO;
                        sel_o.idx  = 6'((int'(ofs_i) - PRIO_LO_BASE) / 4);
                    end else if (int'(ofs_i) >= PRIO_HI_BASE && int'(ofs_i) <= HI_END) begin
                        sel_o.kind = RK_PRIO;
                        sel_o.idx  = 6'(32 + (int'(ofs_i) - PRIO_HI_BASE) / 4);
                    end
                end
            endcase
        end
    end

    // R7: a priority selection never points past the last source
    always_comb begin
        a_r7_prio_idx_range: assert (sel_o.kind != RK_PRIO || int'(sel_o.idx) < NUM_SRC);
    end
endmodule

// File: rtl/ic_view.sv
module ic_view #(
    parameter int NUM_SRC = 40
) (
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic [NUM_SRC-1:0] cls_i,
    output logic [NUM_SRC-1:0] irq_vec_o,
    output logic [NUM_SRC-1:0] fiq_vec_o
);
    logic [NUM_SRC-1:0] live;
    always_comb begin
        live      = pend_i & mask_i;
        irq_vec_o = live & ~cls_i;
        fiq_vec_o = live & cls_i;
    end

    // R3: a source is never in both filtered views
    always_comb begin
        a_r3_views_disjoint: assert ((irq_vec_o & fiq_vec_o) == '0);
    end
endmodule

// File: rtl/ic_route.sv
module ic_route #(
    parameter int NUM_SRC = 40
) (
    input  logic [NUM_SRC-1:0] irq_vec_i,
    input  logic [NUM_SRC-1:0] fiq_vec_i,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic               idle_masked_i,
    input  logic               halted_i,
    output logic               irq_o,
    output logic               fiq_o,
    output logic               wake_o
);
    logic [NUM_SRC-1:0] wake_gate;
    always_comb begin
        irq_o     = |irq_vec_i;
        fiq_o     = |fiq_vec_i;
        wake_gate = idle_masked_i ? mask_i : '1;
        wake_o    = halted_i & (|(pend_i & wake_gate));
    end
endmodule

// File: rtl/banked_intc.sv
module banked_intc
    import ic_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               halted_i,
    input  logic [7:0]         mm_addr_i,
    input  logic               mm_we_i,
    input  logic [31:0]        mm_wdata_i,
    output logic [31:0]        mm_rdata_o,
    input  logic [3:0]         cp_reg_i,
    input  logic               cp_we_i,
    input  logic [31:0]        cp_wdata_i,
    output logic [31:0]        cp_rdata_o,
    input  logic [31:0]        hp_code_i,
    output logic               fiq_o,
    output logic               irq_o,
    output logic               wake_o
);
    localparam int HI_W   = NUM_SRC - 32;
    localparam int PRIO_W = 7;   // valid flag + 6-bit source code
    localparam int NPORT  = 2;   // 0: offset port (wins), 1: coprocessor port

    typedef struct packed {
        logic [NUM_SRC-1:0]             pend;
        logic [NUM_SRC-1:0]             mask;
        logic [NUM_SRC-1:0]             cls;
        logic                           idle_masked;
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
    } regs_t;

    typedef struct packed {
        logic fiq;
        logic irq;
        logic wake;
    } outs_t;

    regs_t regs_d, regs_q;
    outs_t outs_d, outs_q;
    logic  armed_q;

    function automatic logic [31:0] bank_word(input logic [NUM_SRC-1:0] v, input logic b);
        return b ? 32'(v[NUM_SRC-1:32]) : v[31:0];
    endfunction

    // ---------------- port decode ----------------
    logic [7:0]  ofs   [NPORT];
    logic [31:0] wdat  [NPORT];
    logic        we    [NPORT];
    reg_sel_t    sel   [NPORT];
    logic [31:0] rdat  [NPORT];
    logic [7:0]  cp_ofs;

    ic_cpmap u_cpmap (.num_i(cp_reg_i), .ofs_o(cp_ofs));

    always_comb begin
        ofs[0]  = mm_addr_i;
        wdat[0] = mm_wdata_i;
        we[0]   = mm_we_i;
        ofs[1]  = cp_ofs;
        wdat[1] = cp_wdata_i;
        we[1]   = cp_we_i;
    end

    // ---------------- filtered views of current state ----------------
    logic [NUM_SRC-1:0] irqv_q, fiqv_q;
    ic_view #(.NUM_SRC(NUM_SRC)) u_view_q (
        .pend_i(regs_q.pend), .mask_i(regs_q.mask), .cls_i(regs_q.cls),
        .irq_vec_o(irqv_q), .fiq_vec_o(fiqv_q)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        ic_decode #(.NUM_SRC(NUM_SRC)) u_dec (.ofs_i(ofs[p]), .sel_o(sel[p]));

        always_comb begin
            rdat[p] = '0;
            unique case (sel[p].kind)
                RK_IRQP:  rdat[p] = bank_word(irqv_q, sel[p].bank);
                RK_FIQP:  rdat[p] = bank_word(fiqv_q, sel[p].bank);
                RK_RAW:   rdat[p] = bank_word(regs_q.pend, sel[p].bank);
                RK_MASK:  rdat[p] = bank_word(regs_q.mask, sel[p].bank);
                RK_CLASS: rdat[p] = bank_word(regs_q.cls, sel[p].bank);
                RK_CTRL:  rdat[p] = {31'd0, regs_q.idle_masked};
                RK_HP:    rdat[p] = hp_code_i;
                RK_PRIO: begin
                    if (int'(sel[p].idx) < NUM_SRC)
                        rdat[p] = {regs_q.prio[sel[p].idx][6], 25'd0, regs_q.prio[sel[p].idx][5:0]};
                end
                default:  rdat[p] = '0;
            endcase
        end
    end

    assign mm_rdata_o = rdat[0];
    assign cp_rdata_o = rdat[1];

    // ---------------- next state ----------------
    always_comb begin
        regs_d      = regs_q;
        regs_d.pend = src_i;
        // Coprocessor port applied first so the offset port overrides it.
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (we[p]) begin
                case (sel[p].kind)
                    RK_MASK: begin
                        if (sel[p].bank) regs_d.mask[NUM_SRC-1:32] = wdat[p][HI_W-1:0];
                        else             regs_d.mask[31:0]         = wdat[p];
                    end
                    RK_CLASS: begin
                        if (sel[p].bank) regs_d.cls[NUM_SRC-1:32] = wdat[p][HI_W-1:0];
                        else             regs_d.cls[31:0]         = wdat[p];
                    end
                    RK_CTRL: regs_d.idle_masked = wdat[p][0];
                    RK_PRIO: begin
                        if (int'(sel[p].idx) < NUM_SRC)
                            regs_d.prio[sel[p].idx] = {wdat[p][31], wdat[p][5:0]};
                    end
                    default: ;
                endcase
            end
        end
    end

    logic [NUM_SRC-1:0] irqv_d, fiqv_d;
    ic_view #(.NUM_SRC(NUM_SRC)) u_view_d (
        .pend_i(regs_d.pend), .mask_i(regs_d.mask), .cls_i(regs_d.cls),
        .irq_vec_o(irqv_d), .fiq_vec_o(fiqv_d)
    );

    ic_route #(.NUM_SRC(NUM_SRC)) u_route (
        .irq_vec_i(irqv_d), .fiq_vec_i(fiqv_d),
        .pend_i(regs_d.pend), .mask_i(regs_d.mask),
        .idle_masked_i(regs_d.idle_masked), .halted_i(halted_i),
        .irq_o(outs_d.irq), .fiq_o(outs_d.fiq), .wake_o(outs_d.wake)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q  <= '0;
            outs_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            regs_q  <= regs_d;
            outs_q  <= outs_d;
            armed_q <= 1'b1;
        end
    end

    assign fiq_o  = outs_q.fiq;
    assign irq_o  = outs_q.irq;
    assign wake_o = outs_q.wake;

    // ---------------- assertions ----------------
    a_r2_pend_tracks_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q |-> regs_q.pend == $past(src_i));

    a_r5_fiq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fiq_o == (|(regs_q.pend & regs_q.mask & regs_q.cls)));

    a_r5_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == (|(regs_q.pend & regs_q.mask & ~regs_q.cls)));

    a_r6_wake_needs_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && wake_o) |-> $past(halted_i));

    a_r10_bad_cp_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cp_we_i && cp_reg_i > 4'd10 && !mm_we_i)
        |=> ($stable(regs_q.mask) && $stable(regs_q.cls) && $stable(regs_q.idle_masked)));

    a_r11_offset_port_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mm_we_i && cp_we_i && mm_addr_i == OFS_MASK && cp_reg_i == 4'd1)
        |=> regs_q.mask[31:0] == $past(mm_wdata_i));
endmodule

// File: tb/banked_intc_bench.sv
module banked_intc_bench;
    localparam int NS = 40;
    localparam int CLK_HALF = 2;   // 250 MHz

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic          halted = 1'b0;
    logic [7:0]    mm_addr = '0;
    logic          mm_we = 1'b0;
    logic [31:0]   mm_wdata = '0;
    logic [31:0]   mm_rdata;
    logic [3:0]    cp_reg = '0;
    logic          cp_we = 1'b0;
    logic [31:0]   cp_wdata = '0;
    logic [31:0]   cp_rdata;
    logic [31:0]   hp_code = '0;
    logic          fiq, irq, wake;

    always #CLK_HALF clk = ~clk;

    banked_intc #(.NUM_SRC(NS)) u_banked_intc (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .halted_i(halted),
        .mm_addr_i(mm_addr), .mm_we_i(mm_we), .mm_wdata_i(mm_wdata), .mm_rdata_o(mm_rdata),
        .cp_reg_i(cp_reg), .cp_we_i(cp_we), .cp_wdata_i(cp_wdata), .cp_rdata_o(cp_rdata),
        .hp_code_i(hp_code), .fiq_o(fiq), .irq_o(irq), .wake_o(wake)
    );

    typedef struct {
        int          what;   // 0 offset read, 1 coprocessor read, 2 {wake,irq,fiq}
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // Monitor: compares every queued expectation one ns after the next edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.what)
                    0:       act = mm_rdata;
                    1:       act = cp_rdata;
                    default: act = {29'd0, wake, irq, fiq};
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic mmw(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); mm_addr = a; mm_wdata = d; mm_we = 1'b1;
        @(posedge clk); #1; mm_we = 1'b0;
    endtask

    task automatic cpw(input logic [3:0] r, input logic [31:0] d);
        @(negedge clk); cp_reg = r; cp_wdata = d; cp_we = 1'b1;
        @(posedge clk); #1; cp_we = 1'b0;
    endtask

    task automatic mmr(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk); mm_addr = a; mm_we = 1'b0;
        sb.push_back('{what: 0, exp: e, tag: t});
        @(posedge clk); #2;
    endtask

    task automatic cpr(input logic [3:0] r, input logic [31:0] e, input string t);
        @(negedge clk); cp_reg = r; cp_we = 1'b0;
        sb.push_back('{what: 1, exp: e, tag: t});
        @(posedge clk); #2;
    endtask

    // Expectation on {wake, irq, fiq} after the next edge.
    task automatic outs(input logic [2:0] e, input string t);
        @(negedge clk);
        sb.push_back('{what: 2, exp: {29'd0, e}, tag: t});
        @(posedge clk); #2;
    endtask

    task automatic set_src(input logic [NS-1:0] v);
        @(negedge clk); src = v;
    endtask

    initial begin
        #(200000 * 2 * CLK_HALF);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired, all requirements: actual hang expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R12: reset state
        mmr(8'h04, 32'h0, "R12 mask after reset");
        mmr(8'h14, 32'h0, "R12 control after reset");
        mmr(8'h28, 32'h0, "R12 priority after reset");
        outs(3'b000, "R12 outputs after reset");

        // R4: enable and routing read back
        mmw(8'h04, 32'h0000_00F0);
        mmw(8'h08, 32'h0000_0030);
        mmr(8'h04, 32'h0000_00F0, "R4 mask readback");
        mmr(8'h08, 32'h0000_0030, "R4 class readback");

        // R2/R3/R5: mixed pattern
        set_src(40'h00_0000_00F1);
        mmr(8'h10, 32'h0000_00F1, "R2 raw pending");
        mmr(8'h00, 32'h0000_00C0, "R3 irq view");
        mmr(8'h0C, 32'h0000_0030, "R3 fiq view");
        outs(3'b011, "R5 both requests");

        // R2: not latched; only a disabled line remains
        set_src(40'h00_0000_0001);
        mmr(8'h10, 32'h0000_0001, "R2 raw clears with line");
        outs(3'b000, "R5 disabled source raises nothing");

        // R6: wake rules
        @(negedge clk); halted = 1'b1;
        outs(3'b100, "R6 any-pending wake with control 0");
        mmw(8'h14, 32'h0000_0001);
        mmr(8'h14, 32'h0000_0001, "R6 control readback");
        outs(3'b000, "R6 disabled source does not wake with control 1");
        set_src(40'h00_0000_0011);
        outs(3'b101, "R6 enabled fast source wakes");
        @(negedge clk); halted = 1'b0;
        outs(3'b001, "R6 no wake when running");

        // R1: second bank
        mmw(8'hA0, 32'hFFFF_FFFF);
        mmr(8'hA0, 32'h0000_00FF, "R1 bank2 mask width");
        mmw(8'hA4, 32'h0000_0008);
        set_src(40'h08_0000_0000);
        mmr(8'hAC, 32'h0000_0008, "R1 source 35 at bank2 bit 3");
        mmr(8'hA8, 32'h0000_0008, "R1 bank2 fiq view");
        mmr(8'h9C, 32'h0000_0000, "R3 bank2 irq view");
        mmr(8'h10, 32'h0000_0000, "R1 bank1 raw unaffected");
        outs(3'b001, "R5 bank2 fast request");

        // R7: priority word format and placement
        mmw(8'h28, 32'hFFFF_FFFF);
        mmr(8'h28, 32'h8000_003F, "R7 priority 3 kept bits");
        mmw(8'hCC, 32'h1234_5685);
        mmr(8'hCC, 32'h0000_0005, "R7 priority 39 kept bits");
        mmr(8'h2C, 32'h0000_0000, "R7 neighbour untouched");

        // R8: read-only and unmapped
        mmw(8'h10, 32'hFFFF_FFFF);
        mmr(8'h10, 32'h0000_0000, "R8 raw ignores writes");
        mmw(8'hD0, 32'hFFFF_FFFF);
        mmr(8'hD0, 32'h0000_0000, "R8 unmapped reads zero");
        mmr(8'h05, 32'h0000_0000, "R8 misaligned reads zero");
        mmw(8'h06, 32'h0000_0000);
        mmr(8'h04, 32'h0000_00F0, "R8 misaligned write ignored");

        // R9: highest-priority passthrough
        @(negedge clk); hp_code = 32'h8007_0012;
        mmr(8'h18, 32'h8007_0012, "R9 offset read");
        cpr(4'd5, 32'h8007_0012, "R9 coprocessor read");

        // R10: coprocessor map
        cpr(4'd1, 32'h0000_00F0, "R10 cp mask");
        cpr(4'd7, 32'h0000_00FF, "R10 cp bank2 mask");
        cpr(4'd9, 32'h0000_0008, "R10 cp bank2 fiq view");
        cpw(4'd2, 32'h0000_000F);
        mmr(8'h08, 32'h0000_000F, "R10 cp class write");
        cpw(4'd11, 32'h0000_0000);
        mmr(8'h04, 32'h0000_00F0, "R10 invalid cp write ignored");
        cpr(4'd11, 32'h0000_0000, "R10 cp 11 reads zero");
        cpr(4'd15, 32'h0000_0000, "R10 cp 15 reads zero");

        // R11: collision
        @(negedge clk);
        mm_addr = 8'h04; mm_wdata = 32'h0000_0001; mm_we = 1'b1;
        cp_reg = 4'd1;   cp_wdata = 32'h0000_0002; cp_we = 1'b1;
        @(posedge clk); #1; mm_we = 1'b0; cp_we = 1'b0;
        mmr(8'h04, 32'h0000_0001, "R11 offset port wins");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule